// File: doc/BRIEF.md
# PWM Compare Output Channel

This block is one output channel of a general-purpose timer. Every timer clock it compares the counter value, supplied from outside together with the count direction, against an active compare value and registers the result as the raw PWM level. The raw level then passes through a polarity control to the channel pin. Two waveform shapes are available. In shape A the raw level is high once the counter has reached the compare value when counting up. When counting down, it is high while the counter is above the compare value. Shape B is the inverse of shape A.

Software reaches the channel through a small write port with two locations. One is the compare value and the other is a six-bit control word. The compare value either takes effect at once or waits in a shadow register until the counter overflows, depending on a buffering bit. A fast-response bit lets a trigger pulse drive the raw level to its active value in the next clock, without waiting for a compare. A two-bit direction field must be 00 for the channel to act as an output. The counter, dead-time, break handling and interrupts live elsewhere.

Top module: `pwm_cmp_channel`

## Requirements
- R1: In shape A (control bit 3 = 0), counting up (cnt_dn = 0), the raw level registered at a clock edge is 0 when the active compare value is greater than cnt_val and 1 otherwise. pwm_out shows it from that edge on, so the output lags the counter by one clock.
- R2: In shape A, counting down (cnt_dn = 1), the raw level is 1 when the active compare value is less than cnt_val and 0 otherwise, with the same one-clock timing.
- R3: With control bit 3 = 1 (shape B), the raw level is the inverse of the shape-A level for both directions.
- R4: With control bit 2 = 1, pwm_out is the inverse of the raw level. With bit 2 = 0, pwm_out equals the raw level. A change of this bit shows on pwm_out right after the edge that writes it.
- R5: With control bit 0 = 0, a write with wr_sel = 0 loads wr_data into the active compare value at that edge, and the compare in the following cycle uses it.
- R6: With control bit 0 = 1, a compare-value write goes only to the shadow register. The active compare value changes only at an edge where ovf_evt = 1, and then takes the shadow value.
- R7: When ovf_evt and a buffered compare-value write fall on the same edge, the active value takes the shadow value held before that write, and the new data stays in the shadow until the next overflow.
- R8: With control bit 1 = 1, a cycle with trig_evt = 1 registers the raw level as 1 in shape A and as 0 in shape B, whatever the compare would give. With bit 1 = 0, trig_evt has no effect.
- R9: Control bits 5:4 select the channel direction. Only 00 makes the channel an output. Any other value holds pwm_out at 0 and clears the raw level.
- R10: Reset (rst_n = 0) clears the control word, the compare value and the shadow to 0, and holds pwm_out at 0. After reset the channel is unbuffered, without fast response, active-high, shape A and an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_val | input | CNT_W | Current counter value |
| cnt_dn | input | 1 | Count direction, 1 = counting down |
| ovf_evt | input | 1 | One-cycle counter overflow pulse |
| trig_evt | input | 1 | One-cycle trigger event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = compare value, 1 = control word |
| wr_data | input | CNT_W | Write data; the control word uses bits 5:0 |
| pwm_out | output | 1 | Polarized channel output |

## Verification
The counter is swept upward and downward across a fixed compare value so that the cases counter below, equal to and above the compare value are all seen. The equal case is what separates the up rule from the down rule. Each sweep is repeated with shape B and with inverted polarity, which shows that the inversion is applied at the compare and not at the pin. Buffered writes are interleaved with overflow pulses, including a write on the very edge of an overflow, so that the bench can tell a transfer of the old shadow from one of the new data. Trigger pulses are applied with fast response both on and off, and with the direction field set to input, so that the bench can tell a forced level from an ordinary compare result.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

    localparam int CTRL_W = 6;

    // Control word, bit 0 at the bottom:
    // [0] buf_en  [1] fast_en  [2] pol_inv  [3] mode_b  [5:4] dir_cfg
    typedef struct packed {
        logic [1:0] dir_cfg;
        logic       mode_b;
        logic       pol_inv;
        logic       fast_en;
        logic       buf_en;
    } ctrl_t;

    localparam logic [1:0] DIR_OUTPUT = 2'b00;

endpackage

// File: rtl/pwm_cmp_regs.sv
module pwm_cmp_regs
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ovf_evt,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] cmp_active
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // transfer first, from the shadow held before any write this cycle
        if (st_q.ctrl.buf_en && ovf_evt) begin
            st_d.active = st_q.shadow;
        end
        if (wr_en && !wr_sel) begin
            st_d.shadow = wr_data;
            if (!st_q.ctrl.buf_en) begin
                st_d.active = wr_data;
            end
        end
        if (wr_en && wr_sel) begin
            st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl       = st_q.ctrl;
    assign cmp_active = st_q.active;

endmodule

// File: rtl/pwm_cmp_eval.sv
module pwm_cmp_eval #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_dn,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             mode_b,
    input  logic             fast_en,
    input  logic             trig_evt,
    output logic             raw_next
);

    logic up_lvl;
    logic dn_lvl;
    logic shape_a;
    logic forced;

    always_comb begin
        up_lvl   = !(cmp_val > cnt_val);
        dn_lvl   = (cmp_val < cnt_val);
        shape_a  = cnt_dn ? dn_lvl : up_lvl;
        forced   = fast_en && trig_evt;
        raw_next = forced ? !mode_b : (shape_a ^ mode_b);
    end

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_dn,
    input  logic             ovf_evt,
    input  logic             trig_evt,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out
);

    localparam int MIN_W = CTRL_W;

    typedef struct packed {
        logic raw;
    } out_state_t;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_active;
    logic             raw_next;
    logic             is_output;
    out_state_t       os_d, os_q;

    initial begin
        if (CNT_W < MIN_W) $display("pwm_cmp_channel: CNT_W below control width");
    end

    pwm_cmp_regs #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ovf_evt    (ovf_evt),
        .ctrl       (ctrl_q),
        .cmp_active (cmp_active)
    );

    pwm_cmp_eval #(.CNT_W(CNT_W)) eval_i (
        .cnt_val  (cnt_val),
        .cnt_dn   (cnt_dn),
        .cmp_val  (cmp_active),
        .mode_b   (ctrl_q.mode_b),
        .fast_en  (ctrl_q.fast_en),
        .trig_evt (trig_evt),
        .raw_next (raw_next)
    );

    always_comb begin
        is_output = (ctrl_q.dir_cfg == DIR_OUTPUT);
        os_d      = os_q;
        os_d.raw  = is_output ? raw_next : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign pwm_out = is_output && (os_q.raw ^ ctrl_q.pol_inv);

endmodule

// File: rtl/pwm_cmp_channel_chk.sv
module pwm_cmp_channel_chk
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic             cnt_dn,
    input logic             ovf_evt,
    input logic             trig_evt,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             pwm_out,
    input ctrl_t            ctrl_q,
    input logic [CNT_W-1:0] cmp_active,
    input logic             raw_q
);

    logic outp;
    logic no_force;
    assign outp     = (ctrl_q.dir_cfg == DIR_OUTPUT);
    assign no_force = !(ctrl_q.fast_en && trig_evt);

    AST_UP_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (outp && no_force && !cnt_dn && !ctrl_q.mode_b)
        |=> raw_q == !($past(cmp_active) > $past(cnt_val))); // R1

    AST_DOWN_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (outp && no_force && cnt_dn && !ctrl_q.mode_b)
        |=> raw_q == ($past(cmp_active) < $past(cnt_val))); // R2

    AST_SHAPE_B_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (outp && no_force && !cnt_dn && ctrl_q.mode_b)
        |=> raw_q == ($past(cmp_active) > $past(cnt_val))); // R3

    AST_UNBUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !ctrl_q.buf_en)
        |=> cmp_active == $past(wr_data)); // R5

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.buf_en && !ovf_evt)
        |=> $stable(cmp_active)); // R6

    AST_FAST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (outp && ctrl_q.fast_en && trig_evt)
        |=> raw_q == !$past(ctrl_q.mode_b)); // R8

    AST_INPUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.dir_cfg != DIR_OUTPUT) |-> !pwm_out); // R9

    AST_INPUT_RAW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.dir_cfg != DIR_OUTPUT) |=> !raw_q); // R9

    logic unused_ok;
    assign unused_ok = ^{ctrl_q.pol_inv, wr_data, 1'b0};

endmodule

bind pwm_cmp_channel pwm_cmp_channel_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_val    (cnt_val),
    .cnt_dn     (cnt_dn),
    .ovf_evt    (ovf_evt),
    .trig_evt   (trig_evt),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .pwm_out    (pwm_out),
    .ctrl_q     (ctrl_q),
    .cmp_active (cmp_active),
    .raw_q      (os_q.raw)
);

// File: tb/pwm_cmp_channel_tb.sv
module pwm_cmp_channel_tb_top;

    localparam int CNT_W  = 16;
    localparam int CLK_NS = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic             cnt_dn = 1'b0;
    logic             ovf_evt = 1'b0;
    logic             trig_evt = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             pwm_out;

    pwm_cmp_channel #(.CNT_W(CNT_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_val  (cnt_val),
        .cnt_dn   (cnt_dn),
        .ovf_evt  (ovf_evt),
        .trig_evt (trig_evt),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .pwm_out  (pwm_out)
    );

    always #(CLK_NS/2) clk = ~clk;

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    sb_item_t mon_item;
    int n_cmp = 0;
    int n_bad = 0;

    // reference state kept from the requirements
    logic [5:0]       m_ctrl   = '0;
    logic [CNT_W-1:0] m_shadow = '0;
    logic [CNT_W-1:0] m_active = '0;
    logic             m_raw    = 1'b0;
    logic [CNT_W-1:0] cur_cnt  = '0;
    logic             cur_dn   = 1'b0;

    function automatic logic shape_a(input logic [CNT_W-1:0] c, input logic dn,
                                     input logic [CNT_W-1:0] cmp);
        if (dn) return (cmp < c);   // R2
        return !(cmp > c);          // R1
    endfunction

    task automatic step(input logic [CNT_W-1:0] c, input logic dn, input logic ovf,
                        input logic trg, input logic we, input logic sel,
                        input logic [CNT_W-1:0] wd, input string tag);
        sb_item_t it;
        logic     raw_n;
        logic     outp;
        @(negedge clk);
        cnt_val = c; cnt_dn = dn; ovf_evt = ovf; trig_evt = trg;
        wr_en = we; wr_sel = sel; wr_data = wd;
        cur_cnt = c; cur_dn = dn;
        outp = (m_ctrl[5:4] == 2'b00);
        if (!outp) raw_n = 1'b0;                                 // R9
        else if (m_ctrl[1] && trg) raw_n = !m_ctrl[3];           // R8
        else raw_n = shape_a(c, dn, m_active) ^ m_ctrl[3];       // R3
        if (m_ctrl[0] && ovf) m_active = m_shadow;               // R6 R7
        if (we && !sel) begin
            if (!m_ctrl[0]) m_active = wd;                       // R5
            m_shadow = wd;
        end
        if (we && sel) m_ctrl = wd[5:0];
        m_raw  = raw_n;
        it.exp = (m_ctrl[5:4] == 2'b00) && (m_raw ^ m_ctrl[2]);  // R4
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick(input logic [CNT_W-1:0] c, input logic dn, input string tag);
        step(c, dn, 1'b0, 1'b0, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic wr_ctrl(input logic [5:0] v, input string tag);
        step(cur_cnt, cur_dn, 1'b0, 1'b0, 1'b1, 1'b1, CNT_W'(v), tag);
    endtask

    task automatic wr_cmp(input logic [CNT_W-1:0] v, input logic ovf, input string tag);
        step(cur_cnt, cur_dn, ovf, 1'b0, 1'b1, 1'b0, v, tag);
    endtask

    task automatic sweep(input int lo, input int hi, input logic dn, input string tag);
        if (!dn) for (int c = lo; c <= hi; c++) tick(CNT_W'(c), 1'b0, tag);
        else     for (int c = hi; c >= lo; c--) tick(CNT_W'(c), 1'b1, tag);
    endtask

    // monitor: compares one item per clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            mon_item = sb_q.pop_front();
            n_cmp++;
            if (pwm_out !== mon_item.exp) begin
                n_bad++;
                $display("FAIL %s: pwm_out=%0b expected %0b at %0t",
                         mon_item.tag, pwm_out, mon_item.exp, $time);
            end
        end
    end

    initial begin : watchdog
        #(CLK_NS * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_cmp++;
        if (pwm_out !== 1'b0) begin   // r10_ reset holds output low
            n_bad++;
            $display("FAIL R10: pwm_out=%0b expected 0 during reset", pwm_out);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R10: defaults give unbuffered, active-high shape A with compare 0
        tick(3, 1'b0, "R10");
        tick(0, 1'b0, "R10");

        // R5: immediate load, next compare already uses it
        wr_cmp(5, 1'b0, "R5");
        tick(4, 1'b0, "R5");
        tick(5, 1'b0, "R5");

        sweep(0, 9, 1'b0, "R1");
        sweep(0, 9, 1'b1, "R2");

        // R3: shape B, both directions
        wr_ctrl(6'b001000, "R3");
        sweep(0, 9, 1'b0, "R3");
        sweep(0, 9, 1'b1, "R3");

        // R4: inverted polarity, with shape B and then shape A
        wr_ctrl(6'b001100, "R4");
        sweep(3, 7, 1'b0, "R4");
        wr_ctrl(6'b000100, "R4");
        sweep(3, 7, 1'b1, "R4");
        wr_ctrl(6'b000000, "R4");
        tick(6, 1'b0, "R4");

        // R6: buffered write waits for overflow
        wr_ctrl(6'b000001, "R6");
        wr_cmp(2, 1'b0, "R6");
        sweep(0, 6, 1'b0, "R6");
        step(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R6");
        sweep(0, 6, 1'b0, "R6");

        // R7: write on the overflow edge transfers the older shadow
        wr_cmp(3, 1'b0, "R7");
        wr_cmp(7, 1'b1, "R7");
        sweep(1, 8, 1'b0, "R7");
        step(0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R7");
        sweep(1, 8, 1'b0, "R7");

        // R8: trigger without fast response has no effect
        wr_ctrl(6'b000000, "R8");
        wr_cmp(9, 1'b0, "R8");
        step(0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R8");
        tick(1, 1'b0, "R8");
        // R8: fast response forces the active level for the trigger cycle
        wr_ctrl(6'b000010, "R8");
        step(2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R8");
        tick(3, 1'b0, "R8");
        wr_ctrl(6'b001010, "R8");
        step(12, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R8");
        tick(12, 1'b0, "R8");
        wr_ctrl(6'b000110, "R8");
        step(1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R8");

        // R9: non-output direction codes hold the pin low
        wr_ctrl(6'b010010, "R9");
        sweep(7, 12, 1'b0, "R9");
        step(1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R9");
        wr_ctrl(6'b110000, "R9");
        sweep(8, 11, 1'b1, "R9");
        wr_ctrl(6'b100100, "R9");
        tick(2, 1'b0, "R9");
        wr_ctrl(6'b000000, "R9");
        tick(12, 1'b0, "R9");
        tick(2, 1'b0, "R9");

        // boundary: compare value at the top of the range
        wr_cmp({CNT_W{1'b1}}, 1'b0, "R1");
        tick({CNT_W{1'b1}}, 1'b0, "R1");
        tick({CNT_W{1'b1}} - 1, 1'b0, "R1");
        tick({CNT_W{1'b1}}, 1'b1, "R2");

        repeat (3) @(posedge clk);
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule